// File: doc/BRIEF.md
# Multicycle Controller with Memory Wait Stalls

This block is the hardwired sequencing controller of a multicycle processor. Its memories answer after an unknown number of cycles. The controller takes the opcode held in the instruction register, the ALU equality flag, and one wait flag from each memory. It walks each instruction through fetch, decode and operand fetch, execute, memory access and write-back. In every cycle it produces the datapath enables and selects for that step.

Both the fetch state and the two data-access states loop on their own wait flag. The instruction register load, the load-data capture, the register write and the PC update all happen only in the cycle where the matching wait flag is low. While the controller waits, no architectural state changes. The state register is one-hot. Outputs are decoded from the state register and the wait flags, so an access is committed in the same cycle the memory reports it ready.

Top module: `mc_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the controller in fetch with a one-hot state. In fetch, `imem_rd` is 1 and every write enable (`ir_ld`, `s_ld`, `m_ld`, `reg_wr`, `pc_wr`) is 0 while `imem_wait` is high.
- R2: In fetch, `imem_rd` stays at 1 for every cycle that `imem_wait` is high. `ir_ld` is 1 only in the fetch cycle where `imem_wait` is low, and the next cycle is decode.
- R3: Decode lasts one cycle and asserts `ab_ld`, which loads the A and B operand registers from the rs and rt fields. The next state is chosen by the opcode. The default opcodes are: register ALU 6'h01, OR-immediate 6'h02, load 6'h03, store 6'h04, branch-if-equal 6'h05.
- R4: A register ALU instruction spends one execute cycle with `alu_fn`=2 (function code) and `s_ld`=1. It then spends one write-back cycle with `reg_wr`=1, `reg_dst_rd`=1, `wb_from_mem`=0, `pc_wr`=1 and `pc_branch`=0 (PC plus 4).
- R5: An OR-immediate instruction spends one execute cycle with `alu_fn`=3 (OR) and `s_ld`=1. It then spends one write-back cycle with `reg_wr`=1, `reg_dst_rd`=0 (rt), `wb_from_mem`=0 and `pc_wr`=1.
- R6: A load spends one address cycle with `alu_fn`=0 (add) and `s_ld`=1. It then holds `dmem_rd`=1 and asserts `m_ld` only in the cycle where `dmem_wait` is low. A write-back cycle follows with `reg_wr`=1, `wb_from_mem`=1, `reg_dst_rd`=0 and `pc_wr`=1.
- R7: A store spends the same address cycle, then holds `dmem_wr`=1 until `dmem_wait` is low. In that cycle it asserts `pc_wr`=1 with `pc_branch`=0 and then returns to fetch.
- R8: A branch spends one cycle with `alu_fn`=1 (subtract) and `pc_wr`=1. In that cycle `pc_branch` equals `alu_eq`: 1 takes the target, 0 takes the next sequential address. The controller then returns to fetch.
- R9: In every stall cycle, `ir_ld`, `s_ld`, `m_ld`, `reg_wr` and `pc_wr` are all 0. A stall cycle is fetch with `imem_wait` high, or a data state with `dmem_wait` high. The memory strobe (`imem_rd`, `dmem_rd` or `dmem_wr`) stays asserted.
- R10: After decode, an opcode outside the five listed returns to fetch with no register, memory, IR or PC write.
- R11: `imem_wait` has no effect outside fetch, and `dmem_wait` has no effect outside the two data-access states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | OP_W | Opcode field from the instruction register |
| alu_eq | input | 1 | ALU reports operands equal |
| imem_wait | input | 1 | Instruction memory not ready |
| dmem_wait | input | 1 | Data memory not ready |
| imem_rd | output | 1 | Instruction memory read strobe |
| ir_ld | output | 1 | Instruction register load |
| ab_ld | output | 1 | Load A and B operand registers |
| alu_fn | output | 2 | 0 add, 1 subtract, 2 function code, 3 OR |
| s_ld | output | 1 | Load ALU result register |
| dmem_rd | output | 1 | Data memory read strobe |
| dmem_wr | output | 1 | Data memory write strobe |
| m_ld | output | 1 | Load memory data register |
| reg_wr | output | 1 | Register file write |
| reg_dst_rd | output | 1 | Write destination is rd (else rt) |
| wb_from_mem | output | 1 | Write-back data comes from memory data register |
| pc_wr | output | 1 | PC update |
| pc_branch | output | 1 | PC takes branch target (else PC plus 4) |

## Verification
The bench stretches each wait flag from zero to many cycles. A controller that committed early would pulse `ir_ld`, `m_ld` or `pc_wr` during a stall, and one that dropped its strobe would lose the access. It toggles the wait flags at random in states where they should not matter. A controller that sampled the wrong flag would then stall or skip a state. It also runs branches with both equality outcomes and opcodes outside the known set. The unknown opcodes expose a design that writes state or sticks after decode.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;
  localparam int S_FETCH  = 0;
  localparam int S_DECODE = 1;
  localparam int S_EXALU  = 2;
  localparam int S_EXORI  = 3;
  localparam int S_ADDR   = 4;
  localparam int S_MRD    = 5;
  localparam int S_MWR    = 6;
  localparam int S_WBRD   = 7;
  localparam int S_WBRT   = 8;
  localparam int S_WBMEM  = 9;
  localparam int S_BR     = 10;
  localparam int NSTATE   = 11;

  typedef enum logic [1:0] {
    FN_ADD  = 2'd0,
    FN_SUB  = 2'd1,
    FN_FUNC = 2'd2,
    FN_OR   = 2'd3
  } alu_fn_e;

  typedef struct packed {
    logic is_alu;
    logic is_ori;
    logic is_load;
    logic is_store;
    logic is_branch;
  } op_class_t;
endpackage

// File: rtl/mc_ctrl_opdec.sv
module mc_ctrl_opdec
  import mc_ctrl_pkg::*;
#(
  parameter int              OP_W      = 6,
  parameter logic [OP_W-1:0] OP_ALU    = 6'h01,
  parameter logic [OP_W-1:0] OP_ORI    = 6'h02,
  parameter logic [OP_W-1:0] OP_LOAD   = 6'h03,
  parameter logic [OP_W-1:0] OP_STORE  = 6'h04,
  parameter logic [OP_W-1:0] OP_BRANCH = 6'h05
) (
  input  logic [OP_W-1:0] opcode,
  output op_class_t       cls
);
  always_comb begin
    cls           = '0;
    cls.is_alu    = (opcode == OP_ALU);
    cls.is_ori    = (opcode == OP_ORI);
    cls.is_load   = (opcode == OP_LOAD);
    cls.is_store  = (opcode == OP_STORE);
    cls.is_branch = (opcode == OP_BRANCH);
  end
endmodule

// File: rtl/mc_ctrl_next.sv
module mc_ctrl_next
  import mc_ctrl_pkg::*;
#(
  parameter int NST = NSTATE
) (
  input  logic [NST-1:0] cur,
  input  op_class_t      cls,
  input  logic           imem_wait,
  input  logic           dmem_wait,
  output logic [NST-1:0] nxt
);
  always_comb begin
    nxt = '0;
    if (cur[S_FETCH])  nxt[imem_wait ? S_FETCH : S_DECODE] = 1'b1;
    if (cur[S_DECODE]) begin
      if (cls.is_alu)                      nxt[S_EXALU] = 1'b1;
      else if (cls.is_ori)                 nxt[S_EXORI] = 1'b1;
      else if (cls.is_load || cls.is_store) nxt[S_ADDR] = 1'b1;
      else if (cls.is_branch)              nxt[S_BR]    = 1'b1;
      else                                 nxt[S_FETCH] = 1'b1;
    end
    if (cur[S_EXALU]) nxt[S_WBRD] = 1'b1;
    if (cur[S_EXORI]) nxt[S_WBRT] = 1'b1;
    if (cur[S_ADDR])  nxt[cls.is_load ? S_MRD : S_MWR] = 1'b1;
    if (cur[S_MRD])   nxt[dmem_wait ? S_MRD : S_WBMEM] = 1'b1;
    if (cur[S_MWR])   nxt[dmem_wait ? S_MWR : S_FETCH] = 1'b1;
    if (cur[S_WBRD] || cur[S_WBRT] || cur[S_WBMEM] || cur[S_BR])
      nxt[S_FETCH] = 1'b1;
    if (nxt == '0) nxt[S_FETCH] = 1'b1;
  end
endmodule

// File: rtl/mc_ctrl_out.sv
module mc_ctrl_out
  import mc_ctrl_pkg::*;
#(
  parameter int NST = NSTATE
) (
  input  logic [NST-1:0] st,
  input  logic           imem_wait,
  input  logic           dmem_wait,
  input  logic           alu_eq,
  output logic           imem_rd,
  output logic           ir_ld,
  output logic           ab_ld,
  output logic [1:0]     alu_fn,
  output logic           s_ld,
  output logic           dmem_rd,
  output logic           dmem_wr,
  output logic           m_ld,
  output logic           reg_wr,
  output logic           reg_dst_rd,
  output logic           wb_from_mem,
  output logic           pc_wr,
  output logic           pc_branch
);
  alu_fn_e fn;
  logic    wb_any;

  always_comb begin
    if (st[S_EXALU])      fn = FN_FUNC;
    else if (st[S_EXORI]) fn = FN_OR;
    else if (st[S_BR])    fn = FN_SUB;
    else                  fn = FN_ADD;
  end

  assign wb_any      = st[S_WBRD] | st[S_WBRT] | st[S_WBMEM];
  assign imem_rd     = st[S_FETCH];
  assign ir_ld       = st[S_FETCH] & ~imem_wait;
  assign ab_ld       = st[S_DECODE];
  assign alu_fn      = fn;
  assign s_ld        = st[S_EXALU] | st[S_EXORI] | st[S_ADDR];
  assign dmem_rd     = st[S_MRD];
  assign dmem_wr     = st[S_MWR];
  assign m_ld        = st[S_MRD] & ~dmem_wait;
  assign reg_wr      = wb_any;
  assign reg_dst_rd  = st[S_WBRD];
  assign wb_from_mem = st[S_WBMEM];
  assign pc_wr       = wb_any | (st[S_MWR] & ~dmem_wait) | st[S_BR];
  assign pc_branch   = st[S_BR] & alu_eq;
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_ctrl_pkg::*;
#(
  parameter int              OP_W      = 6,
  parameter logic [OP_W-1:0] OP_ALU    = 6'h01,
  parameter logic [OP_W-1:0] OP_ORI    = 6'h02,
  parameter logic [OP_W-1:0] OP_LOAD   = 6'h03,
  parameter logic [OP_W-1:0] OP_STORE  = 6'h04,
  parameter logic [OP_W-1:0] OP_BRANCH = 6'h05
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  input  logic            alu_eq,
  input  logic            imem_wait,
  input  logic            dmem_wait,
  output logic            imem_rd,
  output logic            ir_ld,
  output logic            ab_ld,
  output logic [1:0]      alu_fn,
  output logic            s_ld,
  output logic            dmem_rd,
  output logic            dmem_wr,
  output logic            m_ld,
  output logic            reg_wr,
  output logic            reg_dst_rd,
  output logic            wb_from_mem,
  output logic            pc_wr,
  output logic            pc_branch
);
  localparam int NST = NSTATE;
  localparam logic [NST-1:0] RESET_ST = NST'(1) << S_FETCH;

  op_class_t      cls;
  logic [NST-1:0] state_q;
  logic [NST-1:0] state_d;

  mc_ctrl_opdec #(
    .OP_W(OP_W), .OP_ALU(OP_ALU), .OP_ORI(OP_ORI), .OP_LOAD(OP_LOAD),
    .OP_STORE(OP_STORE), .OP_BRANCH(OP_BRANCH)
  ) opdec_i (
    .opcode (opcode),
    .cls    (cls)
  );

  mc_ctrl_next #(.NST(NST)) next_i (
    .cur       (state_q),
    .cls       (cls),
    .imem_wait (imem_wait),
    .dmem_wait (dmem_wait),
    .nxt       (state_d)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= RESET_ST;
    else     state_q <= state_d;
  end

  mc_ctrl_out #(.NST(NST)) out_i (
    .st          (state_q),
    .imem_wait   (imem_wait),
    .dmem_wait   (dmem_wait),
    .alu_eq      (alu_eq),
    .imem_rd     (imem_rd),
    .ir_ld       (ir_ld),
    .ab_ld       (ab_ld),
    .alu_fn      (alu_fn),
    .s_ld        (s_ld),
    .dmem_rd     (dmem_rd),
    .dmem_wr     (dmem_wr),
    .m_ld        (m_ld),
    .reg_wr      (reg_wr),
    .reg_dst_rd  (reg_dst_rd),
    .wb_from_mem (wb_from_mem),
    .pc_wr       (pc_wr),
    .pc_branch   (pc_branch)
  );
endmodule

// File: rtl/mc_ctrl_chk.sv
module mc_ctrl_chk #(
  parameter int NST = 11
) (
  input logic           clk,
  input logic           rst,
  input logic [NST-1:0] state_q,
  input logic           imem_wait,
  input logic           dmem_wait,
  input logic           imem_rd,
  input logic           ir_ld,
  input logic           ab_ld,
  input logic           s_ld,
  input logic           dmem_rd,
  input logic           dmem_wr,
  input logic           m_ld,
  input logic           reg_wr,
  input logic           wb_from_mem,
  input logic           pc_wr
);
  assert_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $countones(state_q) == 1);

  assert_fetch_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (imem_rd && imem_wait) |=> imem_rd);

  assert_ir_then_decode_R2: assert property (@(posedge clk) disable iff (rst)
    ir_ld |=> (ab_ld && !imem_rd));

  assert_load_wb_R6: assert property (@(posedge clk) disable iff (rst)
    (dmem_rd && !dmem_wait) |=> (reg_wr && wb_from_mem));

  assert_istall_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (imem_rd && imem_wait) |-> !(ir_ld || s_ld || m_ld || reg_wr || pc_wr));

  assert_dstall_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    ((dmem_rd || dmem_wr) && dmem_wait) |-> !(ir_ld || s_ld || m_ld || reg_wr || pc_wr));

  assert_dstall_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (dmem_rd && dmem_wait) |=> dmem_rd);

  assert_wb_to_fetch_R4: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> imem_rd);
endmodule

bind mc_ctrl mc_ctrl_chk #(.NST(NST)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .state_q     (state_q),
  .imem_wait   (imem_wait),
  .dmem_wait   (dmem_wait),
  .imem_rd     (imem_rd),
  .ir_ld       (ir_ld),
  .ab_ld       (ab_ld),
  .s_ld        (s_ld),
  .dmem_rd     (dmem_rd),
  .dmem_wr     (dmem_wr),
  .m_ld        (m_ld),
  .reg_wr      (reg_wr),
  .wb_from_mem (wb_from_mem),
  .pc_wr       (pc_wr)
);

// File: tb/mc_ctrl_tb_top.sv
module mc_ctrl_tb_top;
  localparam logic [5:0] OPA = 6'h01, OPO = 6'h02, OPL = 6'h03, OPS = 6'h04, OPB = 6'h05;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = '0;
  logic alu_eq = 1'b0, imem_wait = 1'b1, dmem_wait = 1'b0;
  logic imem_rd, ir_ld, ab_ld, s_ld, dmem_rd, dmem_wr, m_ld;
  logic reg_wr, reg_dst_rd, wb_from_mem, pc_wr, pc_branch;
  logic [1:0] alu_fn;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mc_ctrl dut_i (
    .clk(clk), .rst(rst), .opcode(opcode), .alu_eq(alu_eq),
    .imem_wait(imem_wait), .dmem_wait(dmem_wait),
    .imem_rd(imem_rd), .ir_ld(ir_ld), .ab_ld(ab_ld), .alu_fn(alu_fn),
    .s_ld(s_ld), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr), .m_ld(m_ld),
    .reg_wr(reg_wr), .reg_dst_rd(reg_dst_rd), .wb_from_mem(wb_from_mem),
    .pc_wr(pc_wr), .pc_branch(pc_branch)
  );

  // order: imem_rd ir_ld ab_ld alu_fn s_ld dmem_rd dmem_wr m_ld reg_wr dst_rd wb_mem pc_wr pc_br
  function automatic logic [14:0] ov(input bit ird, input bit irl, input bit ab, input logic [1:0] fn,
                                      input bit s, input bit drd, input bit dwr, input bit m,
                                      input bit rw, input bit rd, input bit wbm, input bit pw, input bit pb);
    return {ird, irl, ab, fn, s, drd, dwr, m, rw, rd, wbm, pw, pb};
  endfunction

  task automatic chk(input logic [14:0] e, input string req);
    logic [14:0] act;
    #1;
    act = {imem_rd, ir_ld, ab_ld, alu_fn, s_ld, dmem_rd, dmem_wr, m_ld,
           reg_wr, reg_dst_rd, wb_from_mem, pc_wr, pc_branch};
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, e);
    end
    @(negedge clk);
  endtask

  function automatic bit rb();
    return 1'($urandom_range(0, 1));
  endfunction

  task automatic run_instr(input logic [5:0] op, input int iw, input int dw, input bit eq);
    opcode = op;
    alu_eq = eq;
    for (int i = 0; i < iw; i++) begin
      imem_wait = 1; dmem_wait = rb();
      chk(ov(1,0,0,0,0,0,0,0,0,0,0,0,0), "R2 R9 R11 fetch stall");
    end
    imem_wait = 0; dmem_wait = rb();
    chk(ov(1,1,0,0,0,0,0,0,0,0,0,0,0), "R2 fetch accept");
    imem_wait = rb(); dmem_wait = rb();
    chk(ov(0,0,1,0,0,0,0,0,0,0,0,0,0), "R3 R11 decode");
    case (op)
      OPA: begin
        imem_wait = rb(); dmem_wait = rb();
        chk(ov(0,0,0,2,1,0,0,0,0,0,0,0,0), "R4 R11 exec");
        chk(ov(0,0,0,0,0,0,0,0,1,1,0,1,0), "R4 writeback rd");
      end
      OPO: begin
        imem_wait = rb(); dmem_wait = rb();
        chk(ov(0,0,0,3,1,0,0,0,0,0,0,0,0), "R5 exec");
        chk(ov(0,0,0,0,0,0,0,0,1,0,0,1,0), "R5 writeback rt");
      end
      OPL: begin
        imem_wait = rb(); dmem_wait = rb();
        chk(ov(0,0,0,0,1,0,0,0,0,0,0,0,0), "R6 R11 address");
        for (int i = 0; i < dw; i++) begin
          dmem_wait = 1; imem_wait = rb();
          chk(ov(0,0,0,0,0,1,0,0,0,0,0,0,0), "R9 R11 load stall");
        end
        dmem_wait = 0; imem_wait = rb();
        chk(ov(0,0,0,0,0,1,0,1,0,0,0,0,0), "R6 load capture");
        imem_wait = rb(); dmem_wait = rb();
        chk(ov(0,0,0,0,0,0,0,0,1,0,1,1,0), "R6 load writeback");
      end
      OPS: begin
        imem_wait = rb(); dmem_wait = rb();
        chk(ov(0,0,0,0,1,0,0,0,0,0,0,0,0), "R7 address");
        for (int i = 0; i < dw; i++) begin
          dmem_wait = 1; imem_wait = rb();
          chk(ov(0,0,0,0,0,0,1,0,0,0,0,0,0), "R9 store stall");
        end
        dmem_wait = 0; imem_wait = rb();
        chk(ov(0,0,0,0,0,0,1,0,0,0,0,1,0), "R7 store done");
      end
      OPB: begin
        imem_wait = rb(); dmem_wait = rb();
        chk(ov(0,0,0,1,0,0,0,0,0,0,0,1,eq), "R8 branch");
      end
      default: begin
        imem_wait = 1; dmem_wait = rb();
        chk(ov(1,0,0,0,0,0,0,0,0,0,0,0,0), "R10 unknown back to fetch");
      end
    endcase
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] ops [6];
    void'($urandom(32'h5eed_1234));
    ops[0] = OPA; ops[1] = OPO; ops[2] = OPL; ops[3] = OPS; ops[4] = OPB; ops[5] = 6'h3F;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    imem_wait = 1;
    chk(ov(1,0,0,0,0,0,0,0,0,0,0,0,0), "R1 reset state");
    // directed corners
    run_instr(OPA, 0, 0, 0);
    run_instr(OPO, 5, 0, 0);
    run_instr(OPL, 0, 0, 0);
    run_instr(OPL, 2, 9, 0);
    run_instr(OPS, 0, 0, 0);
    run_instr(OPS, 1, 7, 0);
    run_instr(OPB, 0, 0, 1);
    run_instr(OPB, 3, 0, 0);
    run_instr(6'h00, 0, 0, 0);
    run_instr(6'h3F, 2, 0, 0);
    run_instr(OPA, 0, 0, 0);
    // constrained random mix
    for (int n = 0; n < 300; n++)
      run_instr(ops[$urandom_range(0, 5)], $urandom_range(0, 4),
                $urandom_range(0, 4), rb());
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule